// File: doc/BRIEF.md
# Lane Framing Detector with Demux Rotation

This block watches a single demultiplexed lane, the last of four, for the 32-bit framing overhead word. That word is two A1 bytes followed by two A2 bytes. The block reports whether the lane is in frame. While it has no frame it tells the demultiplexer to rotate its lane assignment. The serial bits arrive one per clock cycle in which the bit enable is high. Cycles with the enable low are ignored completely.

From reset the detector searches. The first pattern it finds sets a frame anchor. A second pattern that ends exactly one frame period later puts the detector in frame. If no pattern turns up within the search timeout, the detector sends a one-cycle rotate pulse and the timeout count starts again.

Once in frame, the detector checks one slot per frame. It drops back to search when a set number of slots in a row hold no pattern. The frame period, the search timeout and the miss limit are parameters. The first two are counted in lane bit times.

Top module: `sonet_lane_framer`

## Requirements
- R1: The framing word is 0xF6F62828 (A1 = 0xF6, A2 = 0x28). It is compared against the last 32 enabled bits, with the earliest bit as the most significant.
- R2: After reset, frame_locked is 0 and lane_rotate is 0, and the detector is searching.
- R3: While searching, after SEARCH_TIMEOUT enabled bits with no pattern, lane_rotate is 1 for exactly one clock cycle. That cycle is the one after the clock that took the last of those bits. The timeout count then restarts from zero.
- R4: frame_locked rises in the cycle after the clock that takes the last bit of a second pattern. That pattern must end exactly FRAME_BITS enabled bits after the first one.
- R5: A pattern that ends at any other spacing does not set frame_locked. If the slot one frame after the anchor holds no pattern, the detector returns to search, and a later pattern becomes a new anchor.
- R6: lane_rotate is never asserted while a candidate is being confirmed or while frame_locked is 1.
- R7: In frame, MISS_LIMIT (default 4) consecutive frame slots without the pattern clear frame_locked. The clear shows in the cycle after the last missed slot bit. Fewer misses, or a run of misses broken by a good slot, keep frame_locked at 1.
- R8: Cycles with bit_en low change no state, whatever bit_in carries. Locking and timeouts count only enabled bits.
- R9: rst_n low clears frame_locked and lane_rotate at once, without waiting for a clock edge, and returns the detector to search. Release of the reset is synchronised to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial bit of the monitored lane |
| frame_locked | output | 1 | 1 when in frame, 0 while searching or confirming |
| lane_rotate | output | 1 | One-cycle request to rotate the demux lane assignment |

## Verification
The bench first checks the exact bit on which lock appears. If the spacing count were off by one, lock would land one bit early or late, or never. It then aims a second pattern at a spacing other than one frame and leaves the expected slot empty. A detector that re-anchors or accepts any second pattern would lock here.

It runs three missed slots, then a good slot, then more misses. A miss counter that never clears would drop lock too soon, and one that is off by one would drop it on the wrong slot. The same stimulus is repeated with idle enable-low cycles carrying noise, and a run of rotates is timed back to back, so a counter that runs on idle cycles or fails to restart after a rotate shows up as a misplaced pulse.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam int unsigned FRAME_WORD_W = 32;
  localparam logic [FRAME_WORD_W-1:0] FRAME_WORD = 32'hF6F6_2828;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } fr_state_e;

endpackage

// File: rtl/framer_rst_sync.sv
module framer_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/framer_pattern_match.sv
module framer_pattern_match #(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-1:0] WORD = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic hit
);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (bit_en) sr_d = {sr_q[WORD_W-2:0], bit_in};
  end

  assign hit = bit_en && ({sr_q[WORD_W-2:0], bit_in} == WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // R8
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sr_q));

endmodule

// File: rtl/framer_window_timer.sv
module framer_window_timer #(
  parameter int unsigned FRAME_BITS     = 19440,
  parameter int unsigned SEARCH_TIMEOUT = 155520
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic anchor,
  input  logic search_run,
  output logic at_slot,
  output logic expired
);

  localparam int unsigned PH_W = $clog2(FRAME_BITS);
  localparam int unsigned TO_W = $clog2(SEARCH_TIMEOUT);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_BITS - 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(SEARCH_TIMEOUT - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic [TO_W-1:0] tcnt_q, tcnt_d;

  assign at_slot = bit_en && (phase_q == PH_LAST);
  assign expired = bit_en && search_run && (tcnt_q == TO_LAST);

  always_comb begin
    phase_d = phase_q;
    if (bit_en) begin
      if (anchor || phase_q == PH_LAST) phase_d = '0;
      else                              phase_d = phase_q + 1'b1;
    end
  end

  always_comb begin
    tcnt_d = tcnt_q;
    if (bit_en) begin
      if (!search_run || tcnt_q == TO_LAST) tcnt_d = '0;
      else                                  tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      tcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      tcnt_q  <= tcnt_d;
    end
  end

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(phase_q) && $stable(tcnt_q)));

endmodule

// File: rtl/framer_sync_fsm.sv
module framer_sync_fsm
  import framer_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic at_slot,
  input  logic expired,
  output logic anchor,
  output logic search_run,
  output logic locked,
  output logic rotate
);

  localparam int unsigned MW = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT) : 1;
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

  fr_state_e       st_q, st_d;
  logic [MW-1:0]   miss_q, miss_d;
  logic            rot_q;

  assign anchor     = (st_q == ST_SEARCH) && hit;
  assign search_run = (st_q == ST_SEARCH) && !hit;
  assign locked     = (st_q == ST_SYNC);
  assign rotate     = rot_q;

  always_comb begin
    st_d   = st_q;
    miss_d = miss_q;
    case (st_q)
      ST_SEARCH: begin
        miss_d = '0;
        if (hit) st_d = ST_CONFIRM;
      end
      ST_CONFIRM: begin
        miss_d = '0;
        if (at_slot) st_d = hit ? ST_SYNC : ST_SEARCH;
      end
      ST_SYNC: begin
        if (at_slot) begin
          if (hit) begin
            miss_d = '0;
          end else if (miss_q == MISS_LAST) begin
            miss_d = '0;
            st_d   = ST_SEARCH;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      end
      default: begin
        st_d   = ST_SEARCH;
        miss_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      miss_q <= '0;
      rot_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
      rot_q  <= expired;
    end
  end

  // R3
  rotate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_q |=> !rot_q);

  // R4
  lock_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(at_slot && hit));

  // R7
  drop_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(at_slot && !hit && miss_q == MISS_LAST));

endmodule

// File: rtl/sonet_lane_framer.sv
module sonet_lane_framer
  import framer_pkg::*;
#(
  parameter int unsigned FRAME_BITS     = 19440,
  parameter int unsigned SEARCH_TIMEOUT = 155520,
  parameter int unsigned MISS_LIMIT     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic frame_locked,
  output logic lane_rotate
);

  logic rst_n_i;
  logic hit, at_slot, expired, anchor, search_run;

  framer_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  framer_pattern_match #(
    .WORD_W (FRAME_WORD_W),
    .WORD   (FRAME_WORD)
  ) u_match (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .hit    (hit)
  );

  framer_window_timer #(
    .FRAME_BITS     (FRAME_BITS),
    .SEARCH_TIMEOUT (SEARCH_TIMEOUT)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .bit_en     (bit_en),
    .anchor     (anchor),
    .search_run (search_run),
    .at_slot    (at_slot),
    .expired    (expired)
  );

  framer_sync_fsm #(
    .MISS_LIMIT (MISS_LIMIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .hit        (hit),
    .at_slot    (at_slot),
    .expired    (expired),
    .anchor     (anchor),
    .search_run (search_run),
    .locked     (frame_locked),
    .rotate     (lane_rotate)
  );

  // R6
  no_rotate_locked_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    lane_rotate |-> !frame_locked);

endmodule

// File: tb/tb_sonet_lane_framer.sv
`timescale 1ns/1ps
module tb_sonet_lane_framer;

  localparam int unsigned FB = 96;
  localparam int unsigned TO = 300;
  localparam logic [31:0] PAT = 32'hF6F62828;
  localparam logic [31:0] BAD = 32'hF6F62829;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic frame_locked, lane_rotate;

  int checks = 0;
  int fails = 0;
  int rot_cnt = 0;
  int cyc = 0;
  bit gap_mode = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sonet_lane_framer #(
    .FRAME_BITS(FB), .SEARCH_TIMEOUT(TO), .MISS_LIMIT(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .frame_locked(frame_locked), .lane_rotate(lane_rotate)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (lane_rotate) rot_cnt <= rot_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge after the bit is taken
  task automatic tick(input logic b);
    if (gap_mode) begin
      bit_en = 1'b0;
      for (int g = 0; g < 2; g++) begin
        bit_in = ~b;
        @(negedge clk);
      end
    end
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = 31; i > 31 - n; i--) tick(w[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic do_reset();
    bit_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rot_cnt = 0;
  endtask

  // R2: state after reset
  task automatic t_reset_state();
    do_reset();
    chk(frame_locked == 1'b0, "R2 lock after reset", frame_locked, 0);
    chk(lane_rotate == 1'b0, "R2 rotate after reset", lane_rotate, 0);
  endtask

  // R1 R4: lock on the exact bit of the second pattern (R8 when gap_mode)
  task automatic t_lock(input string tag);
    do_reset();
    send_zeros(10);
    send_word(PAT, 32);
    chk(frame_locked == 1'b0, {tag, " single pattern no lock"}, frame_locked, 0);
    send_zeros(64);
    send_word(PAT, 31);
    chk(frame_locked == 1'b0, {tag, " lock not early"}, frame_locked, 0);
    tick(PAT[0]);
    chk(frame_locked == 1'b1, {tag, " lock on second pattern"}, frame_locked, 1);
    chk(rot_cnt == 0, {tag, " no rotate before timeout"}, rot_cnt, 0);
  endtask

  // R3: rotate timing, pulse width and restart
  task automatic t_rotate();
    do_reset();
    send_zeros(TO - 1);
    chk(lane_rotate == 1'b0 && rot_cnt == 0, "R3 no rotate before timeout", rot_cnt, 0);
    tick(1'b0);
    chk(lane_rotate == 1'b1, "R3 rotate at timeout", lane_rotate, 1);
    tick(1'b0);
    chk(lane_rotate == 1'b0, "R3 rotate is one cycle", lane_rotate, 0);
    send_zeros(TO - 2);
    chk(rot_cnt == 1, "R3 one rotate per timeout", rot_cnt, 1);
    tick(1'b0);
    chk(lane_rotate == 1'b1, "R3 timeout restarts after rotate", lane_rotate, 1);
  endtask

  // R7 R6: miss handling in frame, no rotate while locked
  task automatic t_miss();
    t_lock("R4");
    rot_cnt = 0;
    send_zeros(64);
    for (int k = 0; k < 3; k++) begin
      send_word(BAD, 32);
      chk(frame_locked == 1'b1, "R7 lock kept under limit", frame_locked, 1);
      send_zeros(64);
    end
    send_word(PAT, 32);
    send_zeros(64);
    for (int k = 0; k < 3; k++) begin
      send_word(BAD, 32);
      send_zeros(64);
    end
    chk(frame_locked == 1'b1, "R7 good slot clears miss run", frame_locked, 1);
    send_word(BAD, 31);
    chk(frame_locked == 1'b1, "R7 lock before last miss bit", frame_locked, 1);
    tick(BAD[0]);
    chk(frame_locked == 1'b0, "R7 lock lost on fourth miss", frame_locked, 0);
    chk(rot_cnt == 0, "R6 no rotate while locked", rot_cnt, 0);
    send_zeros(TO - 1);
    chk(lane_rotate == 1'b0, "R3 no rotate early after loss", lane_rotate, 0);
    tick(1'b0);
    chk(lane_rotate == 1'b1, "R3 rotate a timeout after loss", lane_rotate, 1);
  endtask

  // R5: wrong spacing and empty slot do not lock
  task automatic t_spacing();
    do_reset();
    send_zeros(5);
    send_word(PAT, 32);
    send_zeros(40);
    send_word(PAT, 32);
    chk(frame_locked == 1'b0, "R5 wrong spacing no lock", frame_locked, 0);
    send_zeros(24 + 50);
    chk(frame_locked == 1'b0, "R5 empty slot no lock", frame_locked, 0);
    send_word(PAT, 32);
    send_zeros(64);
    send_zeros(32);
    chk(frame_locked == 1'b0, "R5 missing second pattern", frame_locked, 0);
    send_zeros(64);
    send_word(PAT, 32);
    chk(frame_locked == 1'b0, "R5 new anchor needs confirm", frame_locked, 0);
    send_zeros(64);
    send_word(PAT, 32);
    chk(frame_locked == 1'b1, "R5 lock after new anchor", frame_locked, 1);
    chk(rot_cnt == 0, "R6 no rotate while confirming", rot_cnt, 0);
  endtask

  // R9: async reset clears lock immediately
  task automatic t_async_reset();
    t_lock("R4");
    #2 rst_n = 1'b0;
    #1 chk(frame_locked == 1'b0 && lane_rotate == 1'b0, "R9 async clear", frame_locked, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_word(PAT, 32);
    send_zeros(64);
    chk(frame_locked == 1'b0, "R9 search after reset", frame_locked, 0);
  endtask

  initial begin
    t_reset_state();
    t_lock("R1 R4");
    gap_mode = 1'b1;
    t_lock("R8 gaps");
    gap_mode = 1'b0;
    t_rotate();
    t_miss();
    t_spacing();
    t_async_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule